// File: doc/BRIEF.md
# Coincident-Decoded Static RAM Array

This block is a synchronous single-port memory of 1024 words of 8 bits. It does not use one large address decoder. The word address is cut into two halves. The upper half drives a row decoder and the lower half drives a column decoder, and each decoder raises one of 32 select lines. A storage word is written or read only where the active row line and the active column line cross. The array therefore needs 64 select lines in place of 1024.

A single memory-enable input gates all activity. While it is low, both decoders stay dark and the array neither stores nor reports anything, whatever the read/write line says. With enable high, the read/write line chooses the operation. A low level stores the data input into the addressed word on the rising clock edge. A high level loads the addressed word into the output register on the rising clock edge.

A small control machine names the operation taken at each edge, and tracks it in its state register. The states are `OP_IDLE` (enable low), `OP_WRITE` (enable high, read/write low) and `OP_READ` (enable high, read/write high). Every state can move to every other state on any edge, following only the enable and read/write inputs: IDLE→WRITE, IDLE→READ, WRITE→READ, READ→WRITE, WRITE→IDLE, READ→IDLE, and each state back to itself. Reset forces `OP_IDLE`.

Top module: `cdram_top`

## Requirements
- R1: While `mem_en` is 0, no word changes and `rd_data` holds its value, for either level of `rd_wr` and any address or data. The control state becomes `OP_IDLE` on the next edge.
- R2: With `mem_en` = 1 and `rd_wr` = 0, the rising edge stores `wr_data` into the word at `addr`.
- R3: With `mem_en` = 1 and `rd_wr` = 1, `rd_data` equals the addressed word's contents from just after the rising edge.
- R4: A write cycle leaves `rd_data` unchanged, so the output keeps the last value read.
- R5: `addr[9:5]` selects the row and `addr[4:0]` selects the column. Each decoder output is one-hot while `mem_en` is 1 and all zero while `mem_en` is 0.
- R6: A write changes only the word at the crossing of the active row and column. Words that share only its row, or only its column, are left untouched.
- R7: While `rst_n` is low, `rd_data` is 0 and the control state is `OP_IDLE`. Stored words are not cleared.
- R8: A read in the cycle right after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of output register and control state |
| addr | input | 10 | Word address: upper 5 bits row, lower 5 bits column |
| wr_data | input | 8 | Data stored on a write |
| mem_en | input | 1 | Memory enable; 0 blocks every operation |
| rd_wr | input | 1 | 1 = read, 0 = write (only while enabled) |
| rd_data | output | 8 | Registered read data |

## Verification
Two functions can fall in the same cycle: a write changing a stored word, and the output register holding the value of an earlier read. The bench reads a word and then writes a new value to that same word in the very next cycle. It expects `rd_data` to keep the old value through the write, and to show the new value only after a later read. A behavioural model in the bench computes the expected output at every edge. It does the same for idle cycles, in which `rd_wr` and `wr_data` toggle. Corner addresses and their row and column neighbours are read back to confirm that each write lands at a single crossing.

// File: rtl/cdram_pkg.sv
package cdram_pkg;

    // Operation taken at a clock edge, held as the control state
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } op_t;

endpackage

// File: rtl/cdram_onehot_dec.sv
module cdram_onehot_dec #(
    parameter int IN_W = 5,
    localparam int OUT_N = 1 << IN_W
) (
    input  logic             en,
    input  logic [IN_W-1:0]  code,
    output logic [OUT_N-1:0] lines
);

    // One line raised per code value; dark when disabled
    always_comb begin
        lines = '0;
        if (en) begin
            lines[code] = 1'b1;
        end
    end

endmodule

// File: rtl/cdram_ctrl.sv
module cdram_ctrl
    import cdram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mem_en,
    input  logic rd_wr,
    output logic wr_en,
    output logic rd_en,
    output logic dec_en,
    output op_t  state
);

    op_t state_d;

    // Next operation from the enable and direction lines
    always_comb begin
        if (!mem_en) begin
            state_d = OP_IDLE;
        end else if (rd_wr) begin
            state_d = OP_READ;
        end else begin
            state_d = OP_WRITE;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= OP_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // Output decode of the operation taken at the coming edge
    always_comb begin
        wr_en  = 1'b0;
        rd_en  = 1'b0;
        dec_en = 1'b0;
        unique case (state_d)
            OP_IDLE: begin
                dec_en = 1'b0;
            end
            OP_WRITE: begin
                dec_en = 1'b1;
                wr_en  = 1'b1;
            end
            OP_READ: begin
                dec_en = 1'b1;
                rd_en  = 1'b1;
            end
            default: begin
                dec_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cdram_xpt_array.sv
module cdram_xpt_array #(
    parameter int ROWS   = 32,
    parameter int COLS   = 32,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ROWS-1:0]   row_sel,
    input  logic [COLS-1:0]   col_sel,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata
);

    logic [ROWS-1:0][DATA_W-1:0] row_word;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [DATA_W-1:0] cells [COLS];
        logic [DATA_W-1:0] row_pick;

        // Store only where this row line meets the active column line
        always_ff @(posedge clk) begin
            for (int c = 0; c < COLS; c++) begin
                if (wr_en && row_sel[r] && col_sel[c]) begin
                    cells[c] <= din;
                end
            end
        end

        // Column selection within the row
        always_comb begin
            row_pick = '0;
            for (int c = 0; c < COLS; c++) begin
                row_pick = row_pick | (cells[c] & {DATA_W{col_sel[c]}});
            end
        end

        assign row_word[r] = row_pick;
    end

    // Row selection across the array
    always_comb begin
        rdata = '0;
        for (int r = 0; r < ROWS; r++) begin
            rdata = rdata | (row_word[r] & {DATA_W{row_sel[r]}});
        end
    end

endmodule

// File: rtl/cdram_top.sv
module cdram_top
    import cdram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mem_en,
    input  logic              rd_wr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int COL_W = ADDR_W / 2;
    localparam int ROW_W = ADDR_W - COL_W;
    localparam int ROWS  = 1 << ROW_W;
    localparam int COLS  = 1 << COL_W;

    logic              wr_en;
    logic              rd_en;
    logic              dec_en;
    op_t               state;
    logic [ROWS-1:0]   row_sel;
    logic [COLS-1:0]   col_sel;
    logic [DATA_W-1:0] arr_rdata;

    cdram_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .mem_en (mem_en),
        .rd_wr  (rd_wr),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .dec_en (dec_en),
        .state  (state)
    );

    cdram_onehot_dec #(.IN_W(ROW_W)) u_row_dec (
        .en    (dec_en),
        .code  (addr[ADDR_W-1:COL_W]),
        .lines (row_sel)
    );

    cdram_onehot_dec #(.IN_W(COL_W)) u_col_dec (
        .en    (dec_en),
        .code  (addr[COL_W-1:0]),
        .lines (col_sel)
    );

    cdram_xpt_array #(
        .ROWS   (ROWS),
        .COLS   (COLS),
        .DATA_W (DATA_W)
    ) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .row_sel (row_sel),
        .col_sel (col_sel),
        .din     (wr_data),
        .rdata   (arr_rdata)
    );

    // Output register: loads only on a read, otherwise holds
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= arr_rdata;
        end
    end

    // Decoders are one-hot while enabled
    assert_row_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> $onehot(row_sel));
    assert_col_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> $onehot(col_sel));
    // Decoders are dark while disabled
    assert_dec_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_en |-> ($countones({row_sel, col_sel}) == 0));
    // Disabled cycle leaves the output alone and idles the control
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_en |=> ($stable(rd_data) && state == OP_IDLE));
    // Write cycle leaves the output alone
    assert_write_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !rd_wr) |=> $stable(rd_data));

endmodule

// File: tb/cdram_top_bench.sv
`timescale 1ns/1ps
module cdram_top_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [9:0] addr;
    logic [7:0] wr_data;
    logic       mem_en;
    logic       rd_wr;
    logic [7:0] rd_data;

    always #2.5 clk = ~clk;

    cdram_top u_cdram_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_data (wr_data),
        .mem_en  (mem_en),
        .rd_wr   (rd_wr),
        .rd_data (rd_data)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit track  = 0;

    // Behavioural reference model
    logic [7:0] model_mem [1024];
    logic [7:0] model_out;
    string      last_tag;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_out <= 8'h00;
            last_tag  <= "R7";
        end else if (!mem_en) begin
            last_tag <= "R1";
        end else if (rd_wr) begin
            model_out <= model_mem[addr];
            last_tag  <= "R3";
        end else begin
            model_mem[addr] <= wr_data;
            last_tag <= "R4";
        end
    end

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (track && rst_n) begin
            n_run++;
            if (rd_data !== model_out) begin
                n_fail++;
                $display("FAIL %s cycle compare: rd_data=%h expected=%h", last_tag, rd_data, model_out);
            end
        end
    end

    function automatic logic [7:0] pat(int a);
        return 8'((a * 29 + 11) ^ (a >> 5));
    endfunction

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(int a, logic [7:0] d);
        @(negedge clk);
        mem_en = 1'b1; rd_wr = 1'b0; addr = 10'(a); wr_data = d;
    endtask

    task automatic rd(int a, logic [7:0] exp, string tag);
        @(negedge clk);
        mem_en = 1'b1; rd_wr = 1'b1; addr = 10'(a);
        @(negedge clk);
        check(tag, rd_data, exp);
        mem_en = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not end");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] held;
        rst_n = 1'b0; mem_en = 1'b0; rd_wr = 1'b1; addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        check("R7 reset output", rd_data, 8'h00);
        rst_n = 1'b1;
        track = 1'b1;

        // R2: fill every word with a distinct pattern
        for (int a = 0; a < 1024; a++) wr(a, pat(a));
        rd(0,    pat(0),    "R2 fill word 0");
        rd(500,  pat(500),  "R3 read word 500");
        rd(1023, pat(1023), "R3 read word 1023");

        // R6: corner writes, then read corners and their neighbours
        wr(0, 8'hA5); wr(31, 8'h5A); wr(32, 8'hC3); wr(1023, 8'h3C);
        rd(0,    8'hA5,     "R6 corner 0");
        rd(31,   8'h5A,     "R6 corner 31");
        rd(32,   8'hC3,     "R6 corner 32");
        rd(1023, 8'h3C,     "R6 corner 1023");
        rd(1,    pat(1),    "R6 neighbour 1");
        rd(30,   pat(30),   "R6 neighbour 30");
        rd(33,   pat(33),   "R6 neighbour 33");
        rd(63,   pat(63),   "R6 same row as 32");
        rd(992,  pat(992),  "R6 same column as 0");
        rd(1022, pat(1022), "R6 neighbour 1022");

        // R5: same column index in other rows, same row in other columns
        wr(5, 8'h11);
        rd(37,  pat(37),  "R5 row 1 col 5 untouched");
        rd(165, pat(165), "R5 row 5 col 5 untouched");
        rd(6,   pat(6),   "R5 row 0 col 6 untouched");
        rd(5,   8'h11,    "R5 row 0 col 5 written");

        // R1: disabled cycles with write direction and new data
        rd(31, 8'h5A, "R1 setup read");
        held = rd_data;
        @(negedge clk); mem_en = 1'b0; rd_wr = 1'b0; addr = 10'd31; wr_data = 8'hFF;
        @(negedge clk); rd_wr = 1'b1; addr = 10'd600;
        @(negedge clk); rd_wr = 1'b0; addr = 10'd32;
        @(negedge clk);
        check("R1 output held while disabled", rd_data, held);
        rd(31, 8'h5A, "R1 word 31 not written");
        rd(32, 8'hC3, "R1 word 32 not written");

        // R4 and R8: read, then write the same word on the next cycle
        @(negedge clk); mem_en = 1'b1; rd_wr = 1'b1; addr = 10'd32;
        @(negedge clk); rd_wr = 1'b0; wr_data = 8'h77;
        check("R3 read before overwrite", rd_data, 8'hC3);
        @(negedge clk); rd_wr = 1'b1;
        check("R4 output holds through write", rd_data, 8'hC3);
        @(negedge clk); mem_en = 1'b0;
        check("R8 read right after write", rd_data, 8'h77);

        // R8 at a different address with a fresh value
        wr(700, 8'h9E);
        rd(700, 8'h9E, "R8 back-to-back write then read");

        // R7: reset clears the output again but keeps stored words
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R7 output cleared in reset", rd_data, 8'h00);
        rst_n = 1'b1;
        rd(700, 8'h9E, "R7 contents kept over reset");

        repeat (2) @(negedge clk);
        track = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule